// File: doc/BRIEF.md
# Byte Transmit Serializer with Interrupt Status

This block takes bytes from a host over a small register bus and sends them out one bit per bit-rate strobe, most significant bit first. A single holding register sits in front of a shift register; when the shifter has sent its last bit, the next strobe moves the held byte into it and emits that byte's first bit. Back-to-back bytes therefore leave with no gap.

Four sticky status flags describe the transmit stream. Underflow means the shifter needed a byte and none was held. Overflow means the host wrote over a byte that had not yet moved to the shifter. Done means a byte ended with nothing queued behind it. Empty means the holding register has just been drained and may be written. A 4-bit enable mask selects which flags drive the interrupt output. The flags are still set and readable when masked, so the host can poll them. A transmit-enable input gates everything: while it is low, all transmit state is cleared and the status reads zero.

The data write port has no back-pressure. Every write made while transmit is enabled is accepted in the cycle it is made. A write to a full holding register replaces the held byte and raises overflow. The host must use the empty flag or the interrupt as its ready indication.

Top module: `tx_serializer_irq`

## Requirements
- R1: The status readback is 8 bits: bit 3 underflow, bit 2 overflow, bit 1 done, bit 0 empty, bits 7:4 always zero; after reset it reads 0x00, the interrupt output is 0 and the serial output is 0.
- R2: Each byte is sent most significant bit first, one bit per strobe. The strobe after a byte's last bit loads the held byte and emits its first bit, so a continuous stream has no idle bit between bytes.
- R3: Underflow sets on a strobe where the shifter is idle and no byte is held, but only once at least one bit has been sent since transmit was enabled. On such a strobe the serial output is 0.
- R4: A data write while a byte is held, and that byte is not moving to the shifter in the same cycle, sets overflow. The newly written byte replaces the held one.
- R5: Empty sets when a held byte is loaded into the shifter and clears on a data write. If a write and a load fall in the same cycle, empty ends clear and overflow does not set.
- R6: A status read clears underflow, overflow and done in the following cycle; empty is not affected by a read.
- R7: Done sets on the strobe that sends a byte's last bit, when no byte is held and no write is made in that cycle.
- R8: Flags set and read back regardless of the enable mask.
- R9: When a status read and a set event for the same flag fall in the same cycle, the flag ends set.
- R10: While transmit enable is low, the status readback is zero, all flags, the held byte, the shifter and the "bit sent" history are cleared, and data writes are ignored.
- R11: The interrupt output is high exactly when some status bit 3:0 and the matching enable-mask bit (same bit position) are both 1; the mask is written through its own write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable; low clears all transmit state |
| bit_stb | input | 1 | Bit-rate strobe, one cycle per bit |
| dat_we | input | 1 | Data write strobe for the holding register |
| dat_wdata | input | 8 | Byte to transmit |
| ien_we | input | 1 | Enable-mask write strobe |
| ien_wdata | input | 4 | Enable mask, bit positions as in the status |
| sts_re | input | 1 | Status read strobe (clears read-clear flags) |
| sts_rdata | output | 8 | Status readback, combinational from flag state |
| irq | output | 1 | Interrupt request |
| ser_out | output | 1 | Serial data bit |

## Verification
The collisions that matter are a status read landing on the same clock as a new underflow, and a host data write landing on the same strobe that moves the held byte into the shifter. The bench provokes the first by issuing a read together with a strobe on an idle, already-started shifter. It expects underflow to survive (status 0x09). It provokes the second by writing a byte in the same cycle as a loading strobe. It expects empty clear, overflow clear, and both bytes then arriving intact on the serial line, MSB first.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int STS_W = 8;
  localparam int NFLAG = 4;
  typedef struct packed {
    logic under;
    logic ovf;
    logic done;
    logic empty;
  } txs_flags_t;
endpackage

// File: rtl/txs_hold_reg.sv
module txs_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         ovf_evt
);
  assign ovf_evt = en && wr && valid && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (!en) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (wr) begin
      valid <= 1'b1;
      data  <= wdata;
    end else if (take) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/txs_shifter.sv
module txs_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         stb,
  input  logic         hold_valid,
  input  logic [W-1:0] hold_data,
  input  logic         pending,
  output logic         take,
  output logic         ser,
  output logic         under_evt,
  output logic         done_evt
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] left;
  logic          sent_any;
  logic          idle;

  assign idle      = (left == '0);
  assign take      = en && stb && idle && hold_valid;
  assign under_evt = en && stb && idle && !hold_valid && sent_any;
  assign done_evt  = en && stb && (left == CW'(1)) && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; left <= '0; ser <= 1'b0; sent_any <= 1'b0;
    end else if (!en) begin
      sh <= '0; left <= '0; ser <= 1'b0; sent_any <= 1'b0;
    end else if (stb) begin
      if (!idle) begin
        ser      <= sh[W-1];
        sh       <= sh << 1;
        left     <= left - CW'(1);
        sent_any <= 1'b1;
      end else if (hold_valid) begin
        ser      <= hold_data[W-1];
        sh       <= hold_data << 1;
        left     <= CW'(W - 1);
        sent_any <= 1'b1;
      end else begin
        ser <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txs_status.sv
module txs_status
  import txs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rd,
  input  logic             wr,
  input  logic             load,
  input  logic             under_evt,
  input  logic             ovf_evt,
  input  logic             done_evt,
  input  logic [NFLAG-1:0] ien,
  output txs_flags_t       flags,
  output logic             irq
);
  assign irq = en && |(flags & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (!en) begin
      flags <= '0;
    end else begin
      flags.under <= under_evt ? 1'b1 : (rd ? 1'b0 : flags.under);
      flags.ovf   <= ovf_evt   ? 1'b1 : (rd ? 1'b0 : flags.ovf);
      flags.done  <= done_evt  ? 1'b1 : (rd ? 1'b0 : flags.done);
      flags.empty <= wr ? 1'b0 : (load ? 1'b1 : flags.empty);
    end
  end
endmodule

// File: rtl/tx_serializer_irq.sv
module tx_serializer_irq
  import txs_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             bit_stb,
  input  logic             dat_we,
  input  logic [W-1:0]     dat_wdata,
  input  logic             ien_we,
  input  logic [NFLAG-1:0] ien_wdata,
  input  logic             sts_re,
  output logic [STS_W-1:0] sts_rdata,
  output logic             irq,
  output logic             ser_out
);
  logic             wr_ok;
  logic             h_valid;
  logic [W-1:0]     h_data;
  logic             take;
  logic             ovf_evt, under_evt, done_evt;
  logic [NFLAG-1:0] ien_q;
  txs_flags_t       flags;

  assign wr_ok = tx_en && dat_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_we) ien_q <= ien_wdata;
  end

  txs_hold_reg #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .wr(wr_ok), .wdata(dat_wdata),
    .take(take), .valid(h_valid), .data(h_data), .ovf_evt(ovf_evt)
  );

  txs_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .stb(bit_stb),
    .hold_valid(h_valid), .hold_data(h_data), .pending(h_valid || wr_ok),
    .take(take), .ser(ser_out), .under_evt(under_evt), .done_evt(done_evt)
  );

  txs_status u_sts (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .rd(sts_re), .wr(wr_ok),
    .load(take), .under_evt(under_evt), .ovf_evt(ovf_evt),
    .done_evt(done_evt), .ien(ien_q), .flags(flags), .irq(irq)
  );

  assign sts_rdata = tx_en ? {{(STS_W-NFLAG){1'b0}}, flags} : '0;
endmodule

// File: rtl/txs_checker.sv
module txs_checker
  import txs_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             bit_stb,
  input logic             dat_we,
  input logic [W-1:0]     dat_wdata,
  input logic             ien_we,
  input logic [NFLAG-1:0] ien_wdata,
  input logic             sts_re,
  input logic [STS_W-1:0] sts_rdata,
  input logic             irq,
  input logic             ser_out
);
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rdata[7:4] == 4'h0);
  p_under_on_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rdata[3]) |-> $past(bit_stb));
  p_ovf_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rdata[2]) |-> $past(dat_we));
  p_empty_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && dat_we) |=> !sts_rdata[0]);
  p_rd_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_re && !bit_stb && !dat_we) |=> (sts_rdata[3:1] == 3'b000));
  p_done_on_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_rdata[1]) |-> $past(bit_stb));
  p_off_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (sts_rdata == 8'h00));
  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_rdata[3:0] != 4'h0));
endmodule

bind tx_serializer_irq txs_checker #(.W(W)) u_chk (.*);

// File: tb/tb_tx_serializer_irq.sv
`timescale 1ns/1ps
module tb_tx_serializer_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, bit_stb = 1'b0, dat_we = 1'b0, ien_we = 1'b0, sts_re = 1'b0;
  logic [7:0] dat_wdata = '0;
  logic [3:0] ien_wdata = '0;
  logic [7:0] sts_rdata;
  logic       irq, ser_out;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  tx_serializer_irq dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_stb(bit_stb),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .ien_we(ien_we),
    .ien_wdata(ien_wdata), .sts_re(sts_re), .sts_rdata(sts_rdata),
    .irq(irq), .ser_out(ser_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic we, input logic [7:0] wd, input logic stb, input logic re);
    dat_we = we; dat_wdata = wd; bit_stb = stb; sts_re = re;
    @(negedge clk);
    dat_we = 1'b0; bit_stb = 1'b0; sts_re = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    sts_re = 1'b1;
    #1 v = sts_rdata;
    @(negedge clk);
    sts_re = 1'b0;
  endtask

  task automatic set_ien(input logic [3:0] m);
    ien_we = 1'b1; ien_wdata = m;
    @(negedge clk);
    ien_we = 1'b0;
  endtask

  task automatic shift_n(input int n, inout logic [7:0] acc);
    for (int i = 0; i < n; i++) begin
      tick(1'b0, 8'h00, 1'b1, 1'b0);
      acc = {acc[6:0], ser_out};
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset status", sts_rdata, 8'h00);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset ser", ser_out, 0);

    tx_en = 1'b1;
    @(negedge clk);
    tick(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R3 no underflow before first bit", sts_rdata, 8'h00);

    tick(1'b1, 8'hA5, 1'b0, 1'b0);
    chk("R5 write alone sets nothing", sts_rdata, 8'h00);
    tick(1'b1, 8'h3C, 1'b0, 1'b0);
    chk("R4 overflow on write while held", sts_rdata, 8'h04);
    rd(v);
    chk("R6 read returns overflow", v, 8'h04);
    chk("R6 overflow cleared by read", sts_rdata, 8'h00);

    acc = '0;
    shift_n(1, acc);
    chk("R5 empty set on load", sts_rdata, 8'h01);
    chk("R2 first bit of replacing byte", ser_out, 0);
    tick(1'b1, 8'hFF, 1'b0, 1'b0);
    chk("R5 empty cleared by write", sts_rdata, 8'h00);
    shift_n(7, acc);
    chk("R4 R2 newest byte sent MSB first", acc, 8'h3C);
    chk("R7 no done while byte pending", sts_rdata, 8'h00);
    acc = '0;
    shift_n(8, acc);
    chk("R2 back-to-back byte", acc, 8'hFF);
    chk("R7 done at end with nothing pending", sts_rdata, 8'h03);

    tick(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R3 underflow mid-stream", sts_rdata, 8'h0B);
    chk("R3 idle ser is zero", ser_out, 0);
    chk("R8 masked flags give no irq", irq, 0);
    set_ien(4'b1000);
    chk("R11 irq from underflow", irq, 1);
    rd(v);
    chk("R8 read polled status", v, 8'h0B);
    chk("R6 read keeps empty only", sts_rdata, 8'h01);
    chk("R11 irq drops after clear", irq, 0);
    set_ien(4'b0001);
    chk("R11 irq from empty", irq, 1);

    tick(1'b0, 8'h00, 1'b1, 1'b1);
    chk("R9 set wins over same-cycle read", sts_rdata, 8'h09);

    tx_en = 1'b0;
    #1 chk("R10 status zero while disabled", sts_rdata, 8'h00);
    @(negedge clk);
    tick(1'b1, 8'h55, 1'b0, 1'b0);
    chk("R10 irq low while disabled", irq, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R10 flags cleared on re-enable", sts_rdata, 8'h00);
    tick(1'b0, 8'h00, 1'b1, 1'b0);
    chk("R10 write ignored and history cleared", sts_rdata, 8'h00);
    chk("R10 no byte sent", ser_out, 0);

    tick(1'b1, 8'h81, 1'b0, 1'b0);
    acc = '0;
    tick(1'b1, 8'h7E, 1'b1, 1'b0);
    acc = {acc[6:0], ser_out};
    chk("R5 write and load same cycle", sts_rdata, 8'h00);
    shift_n(7, acc);
    chk("R5 loaded byte intact", acc, 8'h81);
    acc = '0;
    shift_n(8, acc);
    chk("R5 same-cycle written byte intact", acc, 8'h7E);
    chk("R7 done after second byte", sts_rdata, 8'h03);

    rd(v);
    for (int b = 0; b < 256; b++) begin
      tick(1'b1, b[7:0], 1'b0, 1'b0);
      acc = '0;
      shift_n(8, acc);
      chk("R2 sweep byte", acc, b);
    end
    chk("R4 R3 sweep flags", sts_rdata, 8'h03);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule